// File: doc/BRIEF.md
# Four-Edge Quadrature Position Counter

This block turns the two phase-shifted pulse trains of a rotary shaft encoder into a signed 16-bit shaft position. Every rising and every falling edge of either channel moves the count by one. An encoder that gives 18 pulses per channel per turn therefore yields 72 counts per revolution. Turning the shaft clockwise, where channel A changes ahead of channel B, raises the count. Turning it counter-clockwise lowers the count.

Both channel inputs are brought into the system clock domain through a two-stage synchroniser. The decoder compares the previous and current two-bit channel state and reads the direction from the Gray-code step between them. A single input step where both channels change together cannot be assigned a direction. Such a step leaves the count alone and latches an error flag. The next position is produced by a group carry look-ahead adder that either adds one or subtracts one, which keeps the update path short across all 16 bits.

Top module: `quad_pos_counter`

## Requirements
- R1: While rst_ni is low, pos_o reads 0 and err_o reads 0.
- R2: The clockwise order of the state {a_i,b_i} is 00, 10, 11, 01, 00. Each legal step in that order adds 1 to pos_o.
- R3: Each single step in the opposite order (00, 01, 11, 10, 00) subtracts 1 from pos_o.
- R4: One full clockwise electrical cycle of four edges moves pos_o by +4. Eighteen such cycles move it by +72.
- R5: If the sampled state is the same as the previous one, pos_o holds.
- R6: A step in which a_i and b_i both change between two samples leaves pos_o unchanged and sets err_o. err_o then stays at 1 until rst_ni is asserted, while later legal steps keep counting.
- R7: pos_o is two's complement and wraps modulo 65536: stepping down from 0 gives 16'hFFFF, and stepping up from 16'h7FFF gives 16'h8000.
- R8: A change on the inputs reaches pos_o on the third rising clock edge after it is applied: two synchroniser stages, then the position register.
- R9: Changes of direction in the middle of a cycle are counted exactly, with each step taken in its own direction.
- R10: Input changes as often as one per clock cycle are all counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 1 | Encoder channel A, asynchronous |
| b_i | input | 1 | Encoder channel B, asynchronous |
| pos_o | output | 16 | Signed shaft position |
| err_o | output | 1 | Sticky flag for a step in which both channels changed |

## Verification
The assertions check the following on every cycle:
- a decoded forward or backward step changes the registered position by exactly one in that direction;
- a held state or an illegal double change freezes the position;
- the error flag never drops outside reset;
- the look-ahead adder agrees with plain arithmetic.

Some properties can only be shown by the bench scenarios, because they depend on the whole input path:
- the three-edge latency;
- the end-to-end count over whole cycles and direction reversals;
- the wrap at the signed limits;
- one-change-per-clock input rates seen through the synchroniser.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  localparam int unsigned PHASES = 4;

  // Position of a channel state along the clockwise sequence 00,10,11,01.
  function automatic logic [1:0] phase_of(input logic [1:0] ab);
    return {ab[0], ab[1] ^ ab[0]};
  endfunction

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_FWD  = 2'd1,
    STEP_BAD  = 2'd2,
    STEP_REV  = 2'd3
  } step_e;
endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    stg_q[s] <= '0;
        else if (s == 0) stg_q[s] <= d_i;
        else            stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/qdec_step.sv
module qdec_step
  import qdec_pkg::*;
(
  input  logic [1:0] prev_i,
  input  logic [1:0] cur_i,
  input  logic       en_i,
  output logic       fwd_o,
  output logic       rev_o,
  output logic       bad_o
);
  logic [1:0] delta;
  step_e      step;

  always_comb begin
    delta = phase_of(cur_i) - phase_of(prev_i);
    step  = en_i ? step_e'(delta) : STEP_HOLD;
    fwd_o = (step == STEP_FWD);
    rev_o = (step == STEP_REV);
    bad_o = (step == STEP_BAD);
  end
endmodule

// File: rtl/qdec_cla_step.sv
module qdec_cla_step #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned GROUP = 4
) (
  input  logic [WIDTH-1:0] val_i,
  input  logic             down_i,
  output logic [WIDTH-1:0] sum_o
);
  localparam int unsigned NGRP = (WIDTH + GROUP - 1) / GROUP;
  localparam int unsigned PADW = NGRP * GROUP;

  logic [PADW-1:0] a, b, p, g, s;
  logic [NGRP:0]   gc;
  logic [NGRP-1:0] gp, gg;

  assign a = PADW'(val_i);
  // +1 or -1 (all ones over the real width).
  assign b = down_i ? PADW'({WIDTH{1'b1}}) : PADW'(1);
  assign p = a ^ b;
  assign g = a & b;
  assign gc[0] = 1'b0;

  generate
    for (genvar k = 0; k < NGRP; k++) begin : g_grp
      logic [GROUP:0] c;
      always_comb begin
        logic pp;
        logic gg_acc;
        gg_acc = 1'b0;
        pp     = 1'b1;
        for (int i = 0; i < GROUP; i++) begin
          gg_acc = g[k*GROUP+i] | (p[k*GROUP+i] & gg_acc);
          pp     = pp & p[k*GROUP+i];
        end
        gg[k] = gg_acc;
        gp[k] = pp;
        // In-group carries from look-ahead terms on the group carry-in.
        c[0] = gc[k];
        for (int i = 0; i < GROUP; i++)
          c[i+1] = g[k*GROUP+i] | (p[k*GROUP+i] & c[i]);
        for (int i = 0; i < GROUP; i++)
          s[k*GROUP+i] = p[k*GROUP+i] ^ c[i];
      end
      assign gc[k+1] = gg[k] | (gp[k] & gc[k]);
    end
  endgenerate

  assign sum_o = s[WIDTH-1:0];
endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter #(
  parameter int unsigned POS_W       = 16,
  parameter int unsigned CLA_GROUP   = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             a_i,
  input  logic             b_i,
  output logic [POS_W-1:0] pos_o,
  output logic             err_o
);
  localparam int unsigned WARM = SYNC_STAGES + 1;

  logic [1:0]       ab_sync, ab_prev_q;
  logic [WARM-1:0]  warm_q;
  logic             live, fwd, rev, bad;
  logic [POS_W-1:0] pos_q, pos_nxt;
  logic             err_q;

  qdec_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({a_i, b_i}),
    .q_o   (ab_sync)
  );

  // Decoding starts once the synchroniser and previous-state register hold real samples.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      warm_q    <= '0;
      ab_prev_q <= '0;
    end else begin
      warm_q    <= {warm_q[WARM-2:0], 1'b1};
      ab_prev_q <= ab_sync;
    end
  end
  assign live = warm_q[WARM-1];

  qdec_step i_step (
    .prev_i(ab_prev_q),
    .cur_i (ab_sync),
    .en_i  (live),
    .fwd_o (fwd),
    .rev_o (rev),
    .bad_o (bad)
  );

  qdec_cla_step #(.WIDTH(POS_W), .GROUP(CLA_GROUP)) i_cla (
    .val_i (pos_q),
    .down_i(rev),
    .sum_o (pos_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (fwd || rev) pos_q <= pos_nxt;
      if (bad)        err_q <= 1'b1;
    end
  end

  assign pos_o = pos_q;
  assign err_o = err_q;

  // R2
  fwd_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd |=> pos_o == POS_W'($past(pos_o) + 1'b1));
  // R3
  rev_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rev |=> pos_o == POS_W'($past(pos_o) - 1'b1));
  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && ab_prev_q == ab_sync) |=> $stable(pos_o));
  // R6
  bad_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad |=> ($stable(pos_o) && err_o));
  // R6
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  // R7
  cla_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_nxt == (rev ? POS_W'(pos_q - 1'b1) : POS_W'(pos_q + 1'b1)));
  // R2 R3 R6
  step_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fwd, rev, bad}));
endmodule

// File: tb/test_quad_pos_counter.sv
`timescale 1ns/1ps
module test_quad_pos_counter;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        a_i = 1'b0;
  logic        b_i = 1'b0;
  logic [15:0] pos_o;
  logic        err_o;

  int unsigned n_cmp = 0, n_bad = 0;
  logic [15:0] exp_pos = '0;
  logic        exp_err = 1'b0;
  logic [1:0]  cur_ab = 2'b00;
  bit          done = 1'b0;

  quad_pos_counter i_quad_pos_counter (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i),
    .pos_o(pos_o), .err_o(err_o)
  );

  always #5 clk_i = ~clk_i;

  // Index of a state in the clockwise order 00,10,11,01.
  function automatic int cw_index(input logic [1:0] ab);
    case (ab)
      2'b00: return 0;
      2'b10: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic logic [1:0] cw_state(input int idx);
    case (idx & 3)
      0: return 2'b00;
      1: return 2'b10;
      2: return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act_p, input logic [15:0] e_p,
                       input logic act_e, input logic e_e);
    n_cmp++;
    if (act_p !== e_p || act_e !== e_e) begin
      n_bad++;
      $display("FAIL %s: pos=%h err=%b expected pos=%h err=%b", req, act_p, act_e, e_p, e_e);
    end
  endtask

  // Drive a new {a,b} and update the reference model.
  task automatic drive(input logic [1:0] ab);
    int d;
    @(negedge clk_i);
    d = (cw_index(ab) - cw_index(cur_ab)) & 3;
    if (d == 1) exp_pos = exp_pos + 16'd1;
    else if (d == 3) exp_pos = exp_pos - 16'd1;
    else if (d == 2) exp_err = 1'b1;
    cur_ab = ab;
    {a_i, b_i} = ab;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk_i);
  endtask

  task automatic step(input int dir); // +1 cw, -1 ccw
    drive(cw_state(cw_index(cur_ab) + dir));
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    exp_pos = '0;
    exp_err = 1'b0;
    @(negedge clk_i);
    check("R1", pos_o, 16'h0, err_o, 1'b0);
    rst_ni = 1'b1;
    settle();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] base;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    check("R1", pos_o, 16'h0, err_o, 1'b0);
    rst_ni = 1'b1;
    settle();
    check("R1", pos_o, 16'h0, err_o, 1'b0);

    // R8 latency: one clockwise step
    drive(2'b10);
    @(negedge clk_i); @(negedge clk_i);
    check("R8", pos_o, 16'h0, err_o, 1'b0);
    @(negedge clk_i);
    check("R8", pos_o, 16'h1, err_o, 1'b0);

    // R2 each clockwise step
    for (int i = 0; i < 7; i++) begin
      step(1); settle(); check("R2", pos_o, exp_pos, err_o, exp_err);
    end
    // R3 each counter-clockwise step
    for (int i = 0; i < 9; i++) begin
      step(-1); settle(); check("R3", pos_o, exp_pos, err_o, exp_err);
    end
    // R5 rewrite the same state
    drive(cur_ab); settle();
    check("R5", pos_o, exp_pos, err_o, exp_err);

    // R4 18 cycles = 72 counts
    base = pos_o;
    for (int i = 0; i < 72; i++) step(1);
    settle();
    check("R4", pos_o, base + 16'd72, err_o, 1'b0);

    // R9 reversals mid-cycle
    for (int i = 0; i < 6; i++) begin
      step(1); step(1); step(-1); settle();
      check("R9", pos_o, exp_pos, err_o, exp_err);
      step(-1); step(-1); step(1); step(-1); settle();
      check("R9", pos_o, exp_pos, err_o, exp_err);
    end

    // R10 random legal moves, one per clock, checked periodically
    for (int i = 0; i < 400; i++) begin
      int r;
      r = int'($urandom_range(2, 0));
      if (r == 0) step(1);
      else if (r == 1) step(-1);
      else drive(cur_ab);
      if (i % 25 == 24) begin
        settle(); check("R10", pos_o, exp_pos, err_o, exp_err);
      end
    end

    // R7 down through zero
    do_reset();
    step(-1); settle();
    check("R7", pos_o, 16'hFFFF, err_o, 1'b0);
    step(1); settle();
    check("R7", pos_o, 16'h0000, err_o, 1'b0);
    // R7 up through 7FFF
    for (int i = 0; i < 32767; i++) step(1);
    settle();
    check("R7", pos_o, 16'h7FFF, err_o, 1'b0);
    step(1); settle();
    check("R7", pos_o, 16'h8000, err_o, 1'b0);

    // R6 illegal double change holds and latches error
    base = exp_pos;
    drive(cw_state(cw_index(cur_ab) + 2)); settle();
    check("R6", pos_o, base, err_o, 1'b1);
    step(1); step(1); settle();
    check("R6", pos_o, base + 16'd2, err_o, 1'b1);
    step(-1); settle();
    check("R6", pos_o, base + 16'd1, err_o, 1'b1);
    do_reset();
    check("R6", pos_o, 16'h0, err_o, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule